// File: doc/BRIEF.md
# Hart-Side Debug Memory Mailbox

This block is the slice of a debug module that a hart reaches over its own memory bus while it runs debug code. It serves a read-only entry stub, a fixed one-word jump that sends the hart into the abstract instruction words, a flag byte per hart, the abstract instruction words themselves, a data buffer and a program buffer. The program buffer directly follows the abstract words, so the hart can run straight from one into the other.

Four store-only mailbox addresses carry the handshake between hart and debugger. A store of the hart's own ID to one of them marks that hart halted or resumed. A store to another acknowledges a launched command. A store to the last one reports an exception. The debugger-side logic drives three plain control pins: launch a command, request a resume and clear error bits. It sees the per-hart halted and resume-acknowledge bits, the busy bit, the error code and both buffers on plain outputs.

The memory port is a request stream and a response stream, both valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. Its response is presented in the next cycle and stays unchanged until `rsp_ready` is seen high. At most one response is held at a time, so a response that is not taken stalls the request side.

Top module: `hart_debug_mailbox`

## Requirements
- R1: `req_ready` is high unless a response is held and `rsp_ready` is low. A request taken at edge N has its response valid after edge N, and `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values while `rsp_ready` is low.
- R2: The word at 0x300 is read-only and reads 0x0400006F. This is a jump-and-link with destination register x0 and offset +0x40, which lands on the abstract words at 0x340.
- R3: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. A read returns the addressed bytes little-endian and right-justified, with the upper bits zero. Stub word i is at 4*i from 0x000. Abstract word i is at 0x340+4*i.
- R4: The program buffer (from 0x340+4*ABS_WORDS) and the data buffer (from 0x380) accept stores of any size, whether or not busy is set. Store data is right-justified. Their contents appear on `progbuf_o` and `data_o` and read back.
- R5: A store to the stub, the jump word, the abstract words or the flag window is refused with `rsp_err` and leaves the content unchanged.
- R6: Each of the following is refused with `rsp_err`, returns read data 0 and changes no state: an unmapped address, a misaligned access, size code 3, a read of a mailbox address, or a store to the halted or resuming address with a size other than 4 bytes.
- R7: A 4-byte store of ID h to 0x100 sets halted bit h. If h equals `sel_hart` and that hart's go flag is clear, busy is also cleared.
- R8: A store to 0x104 clears the go flag of the hart selected by `sel_hart`.
- R9: A 4-byte store of ID h to 0x108 clears halted bit h, sets resume-acknowledge bit h and clears hart h's resume flag.
- R10: A store to 0x10C sets the error code to 3 only when the code is 0. Otherwise the code is left unchanged.
- R11: The flag window 0x400 to 0x7FF holds one byte per hart at 0x400+h. Bit 0 is go, bit 1 is resume and the other bits are 0. Bytes of harts at or above NHARTS read 0.
- R12: `cmd_start` sets go of the selected hart and sets busy. `resume_req` sets the selected hart's resume flag and clears its resume-acknowledge bit. `err_clr` clears the error code bits where it is 1. A mailbox store whose ID is at or above NHARTS is taken without error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Byte offset within the block |
| req_size | input | 2 | 0/1/2 = 1/2/4 bytes, 3 is refused |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Load data, right-justified; 0 for stores and errors |
| rsp_err | output | 1 | Access refused |
| sel_hart | input | HW | Hart selected by the debugger |
| cmd_start | input | 1 | Launch a command on the selected hart |
| resume_req | input | 1 | Request resume of the selected hart |
| err_clr | input | 3 | Write-one-to-clear mask for the error code |
| stub_image | input | ENTRY_WORDS*32 | Entry stub words |
| abs_words | input | ABS_WORDS*32 | Abstract instruction words |
| halted_o | output | NHARTS | Per-hart halted bits |
| resumeack_o | output | NHARTS | Per-hart resume-acknowledge bits |
| busy_o | output | 1 | Command in progress |
| cmderr_o | output | 3 | Error code (3 = exception) |
| data_o | output | DATA_WORDS*32 | Data buffer contents |
| progbuf_o | output | PROG_WORDS*32 | Program buffer contents |

## Verification
The byte-lane path is driven with all three sizes at every lane offset that matters, over the stub, the jump word, the abstract words and both buffers. This separates a wrong shift from a wrong mask. The handshake is run through its whole cycle in order: launch, halt with go still set, acknowledge, halt again, resume request, resume. This shows whether busy is cleared only after the go flag drops. A second hart is selected, and an ID above the hart count is stored, to show whether per-hart state follows the stored ID or the selected hart. The refusals and a held response check that bad accesses touch nothing and that back-pressure freezes the response.

// File: rtl/hdm_pkg.sv
package hdm_pkg;

  localparam int unsigned HALT_OFS  = 32'h100;
  localparam int unsigned GO_OFS    = 32'h104;
  localparam int unsigned RES_OFS   = 32'h108;
  localparam int unsigned EXC_OFS   = 32'h10C;
  localparam int unsigned JUMP_OFS  = 32'h300;
  localparam int unsigned ABS_OFS   = 32'h340;
  localparam int unsigned DATA_OFS  = 32'h380;
  localparam int unsigned FLAG_OFS  = 32'h400;
  localparam int unsigned FLAG_SPAN = 1024;

  localparam logic [2:0] ERR_EXCEPTION = 3'd3;

  typedef enum logic [3:0] {
    RG_NONE, RG_STUB, RG_HALT, RG_GO, RG_RES, RG_EXC,
    RG_JUMP, RG_ABS, RG_PROG, RG_DATA, RG_FLAG
  } region_e;

  // jump-and-link, destination x0, byte offset off
  function automatic logic [31:0] jal_x0(input int off);
    logic [20:0] im;
    im = 21'(off);
    return {im[20], im[10:1], im[11], im[19:12], 5'd0, 7'b1101111};
  endfunction

endpackage

// File: rtl/hdm_decode.sv
module hdm_decode
  import hdm_pkg::*;
#(
  parameter int AW          = 12,
  parameter int ENTRY_WORDS = 4,
  parameter int ABS_WORDS   = 2,
  parameter int PROG_WORDS  = 4,
  parameter int DATA_WORDS  = 2
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          wr,
  output region_e       region,
  output logic [AW-3:0] idx,
  output logic          err
);
  localparam int unsigned STUB_END = ENTRY_WORDS * 4;
  localparam int unsigned PROG_OFS = ABS_OFS + ABS_WORDS * 4;
  localparam int unsigned PROG_END = PROG_OFS + PROG_WORDS * 4;
  localparam int unsigned DATA_END = DATA_OFS + DATA_WORDS * 4;
  localparam int unsigned FLAG_END = FLAG_OFS + FLAG_SPAN;

  int unsigned wa;
  logic misalign, ro, magic;

  always_comb begin
    wa     = 32'(addr) & 32'hFFFF_FFFC;
    region = RG_NONE;
    idx    = '0;
    if (wa < STUB_END) begin
      region = RG_STUB;
      idx    = (AW-2)'(wa >> 2);
    end else if (wa == HALT_OFS) region = RG_HALT;
    else if (wa == GO_OFS)       region = RG_GO;
    else if (wa == RES_OFS)      region = RG_RES;
    else if (wa == EXC_OFS)      region = RG_EXC;
    else if (wa == JUMP_OFS)     region = RG_JUMP;
    else if (wa >= ABS_OFS && wa < PROG_OFS) begin
      region = RG_ABS;
      idx    = (AW-2)'((wa - ABS_OFS) >> 2);
    end else if (wa >= PROG_OFS && wa < PROG_END) begin
      region = RG_PROG;
      idx    = (AW-2)'((wa - PROG_OFS) >> 2);
    end else if (wa >= DATA_OFS && wa < DATA_END) begin
      region = RG_DATA;
      idx    = (AW-2)'((wa - DATA_OFS) >> 2);
    end else if (wa >= FLAG_OFS && wa < FLAG_END) begin
      region = RG_FLAG;
      idx    = (AW-2)'((wa - FLAG_OFS) >> 2);
    end
  end

  always_comb begin
    misalign = (size == 2'd1 && addr[0]) || (size == 2'd2 && addr[1:0] != 2'b00);
    ro       = region inside {RG_STUB, RG_JUMP, RG_ABS, RG_FLAG};
    magic    = region inside {RG_HALT, RG_GO, RG_RES, RG_EXC};
    err      = (size == 2'd3) || misalign || (region == RG_NONE) ||
               (wr && ro) || (!wr && magic) ||
               ((region == RG_HALT || region == RG_RES) && size != 2'd2);
  end

endmodule

// File: rtl/hdm_bufmem.sv
module hdm_bufmem #(
  parameter int WORDS = 4,
  parameter int IW    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [1:0]         wr_off,
  input  logic [1:0]         wr_size,
  input  logic [31:0]        wr_data,
  output logic [WORDS*32-1:0] mem_o
);
  logic [3:0]  bmask;
  logic [31:0] wsh;

  always_comb begin
    case (wr_size)
      2'd0:    bmask = 4'b0001 << wr_off;
      2'd1:    bmask = 4'b0011 << wr_off;
      default: bmask = 4'b1111;
    endcase
    wsh = wr_data << {wr_off, 3'b000};
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && int'(wr_idx) == w) begin
        for (int b = 0; b < 4; b++)
          if (bmask[b]) q[8*b +: 8] <= wsh[8*b +: 8];
      end
    end
    assign mem_o[w*32 +: 32] = q;
  end

endmodule

// File: rtl/hdm_hartstate.sv
module hdm_hartstate
  import hdm_pkg::*;
#(
  parameter int NHARTS = 4,
  parameter int HW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_halt,
  input  logic              ev_go,
  input  logic              ev_res,
  input  logic              ev_exc,
  input  logic [31:0]       ev_id,
  input  logic [HW-1:0]     sel,
  input  logic              cmd_start,
  input  logic              resume_req,
  input  logic [2:0]        err_clr,
  output logic [NHARTS-1:0] halted,
  output logic [NHARTS-1:0] resumeack,
  output logic [NHARTS-1:0] go,
  output logic [NHARTS-1:0] resume,
  output logic              busy,
  output logic [2:0]        cmderr
);
  logic id_ok, sel_ok, sel_go;
  logic [2:0] err_nxt;

  always_comb begin
    id_ok  = ev_id < 32'(NHARTS);
    sel_ok = int'(sel) < NHARTS;
    sel_go = 1'b0;
    for (int h = 0; h < NHARTS; h++)
      if (int'(sel) == h) sel_go = go[h];
    err_nxt = (ev_exc && cmderr == 3'd0) ? ERR_EXCEPTION : cmderr;
  end

  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    logic hit, pick;
    assign hit  = id_ok && ev_id == 32'(h);
    assign pick = sel_ok && int'(sel) == h;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        halted[h]    <= 1'b0;
        resumeack[h] <= 1'b0;
        go[h]        <= 1'b0;
        resume[h]    <= 1'b0;
      end else begin
        if (ev_halt && hit) halted[h] <= 1'b1;
        if (ev_res && hit) begin
          halted[h]    <= 1'b0;
          resumeack[h] <= 1'b1;
          resume[h]    <= 1'b0;
        end
        if (ev_go && pick) go[h] <= 1'b0;
        // debugger-side pulses are applied last
        if (cmd_start && pick) go[h] <= 1'b1;
        if (resume_req && pick) begin
          resume[h]    <= 1'b1;
          resumeack[h] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cmderr <= 3'd0;
    end else begin
      if (ev_halt && id_ok && sel_ok && ev_id == 32'(sel) && !sel_go) busy <= 1'b0;
      if (cmd_start) busy <= 1'b1;
      cmderr <= err_nxt & ~err_clr;
    end
  end

endmodule

// File: rtl/hart_debug_mailbox.sv
module hart_debug_mailbox
  import hdm_pkg::*;
#(
  parameter int AW          = 12,
  parameter int NHARTS      = 4,
  parameter int ENTRY_WORDS = 4,
  parameter int ABS_WORDS   = 2,
  parameter int PROG_WORDS  = 4,
  parameter int DATA_WORDS  = 2,
  localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [1:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_err,
  input  logic [HW-1:0]            sel_hart,
  input  logic                     cmd_start,
  input  logic                     resume_req,
  input  logic [2:0]               err_clr,
  input  logic [ENTRY_WORDS*32-1:0] stub_image,
  input  logic [ABS_WORDS*32-1:0]  abs_words,
  output logic [NHARTS-1:0]        halted_o,
  output logic [NHARTS-1:0]        resumeack_o,
  output logic                     busy_o,
  output logic [2:0]               cmderr_o,
  output logic [DATA_WORDS*32-1:0] data_o,
  output logic [PROG_WORDS*32-1:0] progbuf_o
);
  localparam int IW = AW - 2;
  localparam logic [31:0] JUMP_WORD = jal_x0(int'(ABS_OFS) - int'(JUMP_OFS));

  region_e         region;
  logic [IW-1:0]   idx;
  logic            dec_err, accept, st_ok;
  logic [NHARTS-1:0] go_q, resume_q;
  logic [31:0]     word, shaped, sh;

  hdm_decode #(
    .AW(AW), .ENTRY_WORDS(ENTRY_WORDS), .ABS_WORDS(ABS_WORDS),
    .PROG_WORDS(PROG_WORDS), .DATA_WORDS(DATA_WORDS)
  ) dec_i (
    .addr(req_addr), .size(req_size), .wr(req_write),
    .region(region), .idx(idx), .err(dec_err)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign st_ok     = accept && req_write && !dec_err;

  hdm_bufmem #(.WORDS(DATA_WORDS), .IW(IW)) data_i (
    .clk(clk), .rst_n(rst_n), .wr_en(st_ok && region == RG_DATA),
    .wr_idx(idx), .wr_off(req_addr[1:0]), .wr_size(req_size),
    .wr_data(req_wdata), .mem_o(data_o)
  );

  hdm_bufmem #(.WORDS(PROG_WORDS), .IW(IW)) prog_i (
    .clk(clk), .rst_n(rst_n), .wr_en(st_ok && region == RG_PROG),
    .wr_idx(idx), .wr_off(req_addr[1:0]), .wr_size(req_size),
    .wr_data(req_wdata), .mem_o(progbuf_o)
  );

  hdm_hartstate #(.NHARTS(NHARTS), .HW(HW)) state_i (
    .clk(clk), .rst_n(rst_n),
    .ev_halt(st_ok && region == RG_HALT),
    .ev_go(st_ok && region == RG_GO),
    .ev_res(st_ok && region == RG_RES),
    .ev_exc(st_ok && region == RG_EXC),
    .ev_id(req_wdata), .sel(sel_hart),
    .cmd_start(cmd_start), .resume_req(resume_req), .err_clr(err_clr),
    .halted(halted_o), .resumeack(resumeack_o), .go(go_q),
    .resume(resume_q), .busy(busy_o), .cmderr(cmderr_o)
  );

  // read word select
  always_comb begin
    word = '0;
    case (region)
      RG_STUB: for (int w = 0; w < ENTRY_WORDS; w++)
                 if (int'(idx) == w) word = stub_image[w*32 +: 32];
      RG_JUMP: word = JUMP_WORD;
      RG_ABS:  for (int w = 0; w < ABS_WORDS; w++)
                 if (int'(idx) == w) word = abs_words[w*32 +: 32];
      RG_PROG: for (int w = 0; w < PROG_WORDS; w++)
                 if (int'(idx) == w) word = progbuf_o[w*32 +: 32];
      RG_DATA: for (int w = 0; w < DATA_WORDS; w++)
                 if (int'(idx) == w) word = data_o[w*32 +: 32];
      RG_FLAG: for (int h = 0; h < NHARTS; h++)
                 if (h / 4 == int'(idx))
                   word[(h % 4)*8 +: 8] = {6'd0, resume_q[h], go_q[h]};
      default: word = '0;
    endcase
  end

  // byte lanes, little-endian, right-justified
  always_comb begin
    sh = word >> {req_addr[1:0], 3'b000};
    case (req_size)
      2'd0:    shaped = {24'd0, sh[7:0]};
      2'd1:    shaped = {16'd0, sh[15:0]};
      default: shaped = sh;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= dec_err;
      rsp_rdata <= (!req_write && !dec_err) ? shaped : 32'd0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/hdm_chk.sv
module hdm_chk #(
  parameter int NHARTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              cmd_start,
  input logic [2:0]        err_clr,
  input logic              busy_o,
  input logic [2:0]        cmderr_o,
  input logic [NHARTS-1:0] halted_o
);
  // R1: a held response does not change
  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R1: a response only appears after a taken request
  a_r1_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R12: busy rises only on a launch
  a_r12_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cmd_start));

  // R7: busy falls only after a taken store
  a_r7_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(req_valid && req_ready && req_write));

  // R10: a recorded error is not overwritten
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmderr_o != 3'd0 && err_clr == 3'd0) |=> cmderr_o == $past(cmderr_o));

  // R9: halted bits drop only after a taken store
  a_r9_halt_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(halted_o) < $countones($past(halted_o))) |->
      $past(req_valid && req_ready && req_write));
endmodule

bind hart_debug_mailbox hdm_chk #(.NHARTS(NHARTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cmd_start(cmd_start),
  .err_clr(err_clr), .busy_o(busy_o), .cmderr_o(cmderr_o), .halted_o(halted_o)
);

// File: tb/hart_debug_mailbox_tb_top.sv
`timescale 1ns/1ps
module hart_debug_mailbox_tb_top;
  localparam int AW = 12, NH = 4, EW = 4, AWD = 2, PW = 4, DW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1, rsp_err;
  logic [31:0] rsp_rdata;
  logic [1:0] sel_hart = '0;
  logic cmd_start = 0, resume_req = 0;
  logic [2:0] err_clr = '0;
  logic [EW*32-1:0] stub_image = {32'hDDEEFF00, 32'h99AABBCC, 32'h55667788, 32'h11223344};
  logic [AWD*32-1:0] abs_words = {32'h00100073, 32'h00000013};
  logic [NH-1:0] halted_o, resumeack_o;
  logic busy_o;
  logic [2:0] cmderr_o;
  logic [DW*32-1:0] data_o;
  logic [PW*32-1:0] progbuf_o;

  always #4 clk = ~clk;

  hart_debug_mailbox #(.AW(AW), .NHARTS(NH), .ENTRY_WORDS(EW), .ABS_WORDS(AWD),
    .PROG_WORDS(PW), .DATA_WORDS(DW)) dut_i (.*);

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] exp_d_q[$];
  logic exp_e_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_d_q.size() == 0) begin
        chk(0, "R1 unexpected response", rsp_rdata, 32'd0);
      end else begin
        logic [31:0] ed;
        logic ee;
        string t;
        ed = exp_d_q.pop_front();
        ee = exp_e_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == ed, {t, " data"}, rsp_rdata, ed);
        chk(rsp_err == ee, {t, " err"}, 32'(rsp_err), 32'(ee));
      end
    end
  end

  task automatic bus(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input logic [31:0] ed, input bit ee, input string t);
    exp_d_q.push_back(ed);
    exp_e_q.push_back(ee);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] ed,
                    input bit ee, input string t);
    bus(0, a, sz, 32'd0, ed, ee, t);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz, input logic [31:0] wd,
                    input bit ee, input string t);
    bus(1, a, sz, wd, 32'd0, ee, t);
  endtask

  task automatic pulse_start();
    @(negedge clk); cmd_start = 1; @(negedge clk); cmd_start = 0;
  endtask
  task automatic pulse_resume();
    @(negedge clk); resume_req = 1; @(negedge clk); resume_req = 0;
  endtask
  task automatic pulse_clr(input logic [2:0] m);
    @(negedge clk); err_clr = m; @(negedge clk); err_clr = 0;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    chk(0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(req_ready == 1 && rsp_valid == 0, "R1 reset handshake", {30'd0, req_ready, rsp_valid}, 32'h2);
    chk(busy_o == 0 && cmderr_o == 0, "R12 reset busy/err", {28'd0, busy_o, cmderr_o}, 0);
    chk(halted_o == 0 && resumeack_o == 0, "R7 reset hart bits", {halted_o, resumeack_o}, 0);

    // R2 jump word
    rd(12'h300, 2, 32'h0400006F, 0, "R2 jump word");
    rd(12'h303, 0, 32'h04, 0, "R2 jump top byte");
    rd(12'h302, 1, 32'h0400, 0, "R2 jump upper half");

    // R3 byte lanes on stub and abstract words
    rd(12'h001, 0, 32'h33, 0, "R3 stub byte1");
    rd(12'h006, 1, 32'h5566, 0, "R3 stub half");
    rd(12'h00C, 2, 32'hDDEEFF00, 0, "R3 stub word3");
    rd(12'h344, 2, 32'h00100073, 0, "R3 abstract word1");

    // R4 buffers
    wr(12'h380, 2, 32'hDEADBEEF, 0, "R4 data word");
    wr(12'h381, 0, 32'h55, 0, "R4 data byte");
    chk(data_o[31:0] == 32'hDEAD55EF, "R4 data_o", data_o[31:0], 32'hDEAD55EF);
    rd(12'h380, 2, 32'hDEAD55EF, 0, "R4 data readback");
    wr(12'h34A, 1, 32'h1234, 0, "R4 progbuf half");
    chk(progbuf_o[31:0] == 32'h12340000, "R4 progbuf_o", progbuf_o[31:0], 32'h12340000);
    rd(12'h348, 2, 32'h12340000, 0, "R4 progbuf readback");

    // R5 read-only windows
    wr(12'h300, 2, 32'hFFFFFFFF, 1, "R5 store jump");
    rd(12'h300, 2, 32'h0400006F, 0, "R5 jump unchanged");
    wr(12'h344, 2, 32'h0, 1, "R5 store abstract");
    rd(12'h344, 2, 32'h00100073, 0, "R5 abstract unchanged");
    wr(12'h401, 0, 32'h01, 1, "R5 store flag");
    rd(12'h401, 0, 32'h00, 0, "R5 flag unchanged");

    // R6 refusals
    rd(12'h200, 2, 32'h0, 1, "R6 unmapped");
    rd(12'h800, 2, 32'h0, 1, "R6 unmapped high");
    rd(12'h381, 1, 32'h0, 1, "R6 misaligned");
    rd(12'h380, 3, 32'h0, 1, "R6 size3");
    rd(12'h100, 2, 32'h0, 1, "R6 read mailbox");
    wr(12'h100, 0, 32'h0, 1, "R6 halted byte store");
    chk(halted_o == 0, "R6 halted untouched", 32'(halted_o), 0);

    // R12 / R7 / R8 command handshake on hart 1
    sel_hart = 1;
    pulse_start();
    chk(busy_o == 1, "R12 busy set", 32'(busy_o), 1);
    rd(12'h401, 0, 32'h01, 0, "R12 go flag set");
    wr(12'h384, 2, 32'hCAFEF00D, 0, "R4 store while busy");
    chk(data_o[63:32] == 32'hCAFEF00D, "R4 data while busy", data_o[63:32], 32'hCAFEF00D);
    wr(12'h100, 2, 32'd1, 0, "R7 halted with go");
    chk(halted_o == 4'b0010, "R7 halted bit", 32'(halted_o), 32'h2);
    chk(busy_o == 1, "R7 busy kept while go", 32'(busy_o), 1);
    wr(12'h104, 2, 32'd0, 0, "R8 going");
    rd(12'h401, 0, 32'h00, 0, "R8 go cleared");
    wr(12'h100, 2, 32'd1, 0, "R7 halted again");
    chk(busy_o == 0, "R7 busy cleared", 32'(busy_o), 0);

    // R9 resume
    pulse_resume();
    rd(12'h401, 0, 32'h02, 0, "R12 resume flag set");
    wr(12'h108, 2, 32'd1, 0, "R9 resuming");
    chk(halted_o == 0 && resumeack_o == 4'b0010, "R9 hart bits",
        {halted_o, resumeack_o}, 32'h02);
    rd(12'h401, 0, 32'h00, 0, "R9 resume flag cleared");
    pulse_resume();
    chk(resumeack_o == 0, "R12 resumeack cleared", 32'(resumeack_o), 0);
    wr(12'h108, 2, 32'd1, 0, "R9 resume again");

    // R11 flag window layout
    sel_hart = 0;
    pulse_start();
    sel_hart = 3;
    pulse_resume();
    rd(12'h400, 2, 32'h02000001, 0, "R11 flag word");
    rd(12'h403, 0, 32'h02, 0, "R11 flag byte hart3");
    rd(12'h7FC, 2, 32'h0, 0, "R11 absent harts");
    sel_hart = 0;
    wr(12'h104, 2, 32'd0, 0, "R8 going hart0");
    wr(12'h100, 2, 32'd0, 0, "R7 halted hart0");
    chk(busy_o == 0 && halted_o == 4'b0001, "R7 hart0 halted, idle",
        {27'd0, busy_o, halted_o}, 32'h01);

    // R12 out-of-range ID
    wr(12'h100, 2, 32'd9, 0, "R12 bad id halted");
    wr(12'h108, 2, 32'd9, 0, "R12 bad id resuming");
    chk(halted_o == 4'b0001, "R12 bad id ignored", 32'(halted_o), 32'h1);

    // R10 exception
    wr(12'h10C, 0, 32'd0, 0, "R10 exception");
    chk(cmderr_o == 3, "R10 code set", 32'(cmderr_o), 3);
    pulse_clr(3'b001);
    chk(cmderr_o == 2, "R12 partial clear", 32'(cmderr_o), 2);
    wr(12'h10C, 2, 32'd0, 0, "R10 exception again");
    chk(cmderr_o == 2, "R10 no overwrite", 32'(cmderr_o), 2);
    pulse_clr(3'b111);
    wr(12'h10C, 2, 32'd0, 0, "R10 exception after clear");
    chk(cmderr_o == 3, "R10 code set again", 32'(cmderr_o), 3);

    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    rd(12'h300, 2, 32'h0400006F, 0, "R1 held response");
    chk(rsp_valid == 1 && req_ready == 0, "R1 stall", {30'd0, rsp_valid, req_ready}, 32'h2);
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1 && rsp_rdata == 32'h0400006F, "R1 held data", rsp_rdata, 32'h0400006F);
    rsp_ready = 1;
    repeat (3) @(negedge clk);
    chk(exp_d_q.size() == 0 && rsp_valid == 0, "R1 drained", 32'(exp_d_q.size()), 0);
    finish_run();
  end
endmodule